// File: doc/BRIEF.md
# Byte Lane Insert Extract Unit

This unit sits beside an execution pipeline and moves single bytes into and out of a 32-bit container word. An insert writes an 8-bit value into one chosen byte lane of the word and passes the other lanes through untouched. An extract picks one lane out of the word and returns it zero-extended to the full word width. The answer is registered and appears one clock after the request strobe, with a valid flag.

To stream a run of bytes, the unit holds its own lane index, which can step forward after every operation. When the index steps past the top lane and wraps to zero, the unit also bumps a register pointer: the destination pointer for inserts, the source pointer for extracts. A string of bytes can therefore be packed into, or unpacked from, consecutive registers without any extra instructions. A request can either use the held index or load a fresh one, and both pointers can be loaded directly.

Top module: `byte_lane_unit`

## Requirements
- R1: Lanes are numbered little-endian: lane k occupies bits 8k+7 down to 8k, so lane 0 is bits 7:0 and lane 3 is bits 31:24; the lane index is 2 bits wide.
- R2: An insert (`op_kind` = 0) returns `word_in` with the selected lane replaced by `byte_in` and the other three lanes unchanged.
- R3: An extract (`op_kind` = 1) returns the selected lane of `word_in` in bits 7:0 with bits 31:8 zero.
- R4: `res_valid` is high for exactly the cycle after each `op_valid` cycle; `result` is updated only then and holds its value otherwise.
- R5: With `idx_load` = 1 the operation uses `lane_in`; with `idx_load` = 0 it uses the held index shown on `lane_idx`.
- R6: With `auto_inc` = 1, after an operation `lane_idx` becomes the used index plus one, wrapping from 3 to 0.
- R7: With `auto_inc` = 0, after an operation `lane_idx` equals the used index and neither pointer changes.
- R8: With `auto_inc` = 1, an insert that uses lane 3 advances `dst_ptr` by one (modulo 2^PTR_W) and leaves `src_ptr` unchanged.
- R9: With `auto_inc` = 1, an extract that uses lane 3 advances `src_ptr` by one (modulo 2^PTR_W) and leaves `dst_ptr` unchanged.
- R10: `ptr_load` = 1 loads `dst_ptr_in` and `src_ptr_in` into the pointers on the next edge, taking priority over any advance in that same cycle.
- R11: A synchronous active-high `rst` clears `lane_idx`, both pointers, `result` and `res_valid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 1 | 0 = insert, 1 = extract |
| idx_load | input | 1 | Use `lane_in` instead of the held index |
| lane_in | input | 2 | Explicit lane index |
| auto_inc | input | 1 | Post-increment the index after the operation |
| word_in | input | 32 | Container word |
| byte_in | input | 8 | Byte to insert |
| ptr_load | input | 1 | Load both register pointers |
| dst_ptr_in | input | 9 | Destination pointer load value |
| src_ptr_in | input | 9 | Source pointer load value |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 32 | Updated word or zero-extended byte |
| lane_idx | output | 2 | Held lane index |
| dst_ptr | output | 9 | Destination register pointer |
| src_ptr | output | 9 | Source register pointer |

## Verification
Inserts and extracts are driven into every lane with explicit indices and words whose bytes are all distinct, so a wrong lane, a swapped lane order or a corrupted neighbour shows up as a different byte value; an extract of 0xFF on a word full of ones separates true zero extension from a sign or leftover fill. Streams of eight back-to-back operations with post-increment cross the 3-to-0 wrap twice, telling apart which pointer advances for inserts versus extracts, and a pointer loaded at its maximum value checks the modulo wrap. Runs with post-increment off, idle gaps, a pointer load colliding with a wrap, and a reset in mid-stream show that state holds or clears exactly as required.

// File: rtl/byte_lane_pkg.sv
package byte_lane_pkg;

    typedef enum logic {
        LANE_INSERT  = 1'b0,
        LANE_EXTRACT = 1'b1
    } lane_op_e;

    // index width needed to name a lane, at least one bit
    function automatic int lane_idx_width(input int lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

endpackage

// File: rtl/bl_lane_mux.sv
module bl_lane_mux
    import byte_lane_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8,
    localparam int NUM_LANES = WORD_W / LANE_W,
    localparam int IDX_W = lane_idx_width(NUM_LANES)
) (
    input  lane_op_e            op,
    input  logic [IDX_W-1:0]    idx,
    input  logic [WORD_W-1:0]   word,
    input  logic [LANE_W-1:0]   value,
    output logic [WORD_W-1:0]   res
);

    logic [NUM_LANES-1:0] hit;
    logic [WORD_W-1:0]    merged;
    logic [LANE_W-1:0]    lane_data [NUM_LANES];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign hit[g] = (idx == IDX_W'(g));
        assign lane_data[g] = word[g*LANE_W +: LANE_W];
        assign merged[g*LANE_W +: LANE_W] = hit[g] ? value : lane_data[g];
    end

    logic [LANE_W-1:0] picked;

    always_comb begin
        picked = '0;
        for (int k = 0; k < NUM_LANES; k++) begin
            picked |= hit[k] ? lane_data[k] : '0;
        end
    end

    always_comb begin
        if (op == LANE_INSERT) res = merged;
        else                   res = {{(WORD_W-LANE_W){1'b0}}, picked};
    end

endmodule

// File: rtl/bl_seq.sv
module bl_seq
    import byte_lane_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int PTR_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  lane_op_e         op,
    input  logic             idx_load,
    input  logic [IDX_W-1:0] lane_in,
    input  logic             auto_inc,
    input  logic             ptr_load,
    input  logic [PTR_W-1:0] dst_in,
    input  logic [PTR_W-1:0] src_in,
    output logic [IDX_W-1:0] idx_used,
    output logic [IDX_W-1:0] idx_q,
    output logic [PTR_W-1:0] dst_q,
    output logic [PTR_W-1:0] src_q
);

    logic wrap;

    assign idx_used = idx_load ? lane_in : idx_q;
    assign wrap     = fire && auto_inc && (idx_used == {IDX_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (fire) begin
            idx_q <= auto_inc ? idx_used + 1'b1 : idx_used;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_q <= '0;
            src_q <= '0;
        end else if (ptr_load) begin
            dst_q <= dst_in;
            src_q <= src_in;
        end else if (wrap) begin
            if (op == LANE_INSERT) dst_q <= dst_q + 1'b1;
            else                   src_q <= src_q + 1'b1;
        end
    end

endmodule

// File: rtl/byte_lane_unit.sv
module byte_lane_unit
    import byte_lane_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8,
    parameter int PTR_W  = 9,
    localparam int NUM_LANES = WORD_W / LANE_W,
    localparam int IDX_W = lane_idx_width(NUM_LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_kind,
    input  logic              idx_load,
    input  logic [IDX_W-1:0]  lane_in,
    input  logic              auto_inc,
    input  logic [WORD_W-1:0] word_in,
    input  logic [LANE_W-1:0] byte_in,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  dst_ptr_in,
    input  logic [PTR_W-1:0]  src_ptr_in,
    output logic              res_valid,
    output logic [WORD_W-1:0] result,
    output logic [IDX_W-1:0]  lane_idx,
    output logic [PTR_W-1:0]  dst_ptr,
    output logic [PTR_W-1:0]  src_ptr
);

    lane_op_e          op;
    logic [IDX_W-1:0]  idx_used;
    logic [WORD_W-1:0] mux_res;

    assign op = lane_op_e'(op_kind);

    bl_seq #(.IDX_W(IDX_W), .PTR_W(PTR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .fire     (op_valid),
        .op       (op),
        .idx_load (idx_load),
        .lane_in  (lane_in),
        .auto_inc (auto_inc),
        .ptr_load (ptr_load),
        .dst_in   (dst_ptr_in),
        .src_in   (src_ptr_in),
        .idx_used (idx_used),
        .idx_q    (lane_idx),
        .dst_q    (dst_ptr),
        .src_q    (src_ptr)
    );

    bl_lane_mux #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_mux (
        .op    (op),
        .idx   (idx_used),
        .word  (word_in),
        .value (byte_in),
        .res   (mux_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            result    <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) result <= mux_res;
        end
    end

endmodule

// File: rtl/bl_chk.sv
module bl_chk #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8,
    parameter int PTR_W  = 9,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic              op_kind,
    input logic              idx_load,
    input logic [IDX_W-1:0]  lane_in,
    input logic              auto_inc,
    input logic [WORD_W-1:0] word_in,
    input logic [LANE_W-1:0] byte_in,
    input logic              ptr_load,
    input logic              res_valid,
    input logic [WORD_W-1:0] result,
    input logic [IDX_W-1:0]  lane_idx,
    input logic [PTR_W-1:0]  dst_ptr,
    input logic [PTR_W-1:0]  src_ptr
);

    // R4
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R4
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && $stable(result)));

    // R3
    zext_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind) |=> (result[WORD_W-1:LANE_W] == '0));

    // R2
    insert_low_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_kind && idx_load && lane_in == '0) |=>
        (result[WORD_W-1:LANE_W] == $past(word_in[WORD_W-1:LANE_W]) &&
         result[LANE_W-1:0] == $past(byte_in)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !auto_inc && !idx_load && !ptr_load) |=>
        ($stable(lane_idx) && $stable(dst_ptr) && $stable(src_ptr)));

    // R8
    dst_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && auto_inc && !op_kind && !idx_load && !ptr_load &&
         lane_idx == '1) |=>
        (dst_ptr == PTR_W'($past(dst_ptr) + 1'b1) && $stable(src_ptr) &&
         lane_idx == '0));

    // R9
    src_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && auto_inc && op_kind && !idx_load && !ptr_load &&
         lane_idx == '1) |=>
        (src_ptr == PTR_W'($past(src_ptr) + 1'b1) && $stable(dst_ptr)));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (lane_idx == '0 && dst_ptr == '0 && src_ptr == '0 &&
                 !res_valid && result == '0));

endmodule

bind byte_lane_unit bl_chk #(
    .WORD_W(WORD_W), .LANE_W(LANE_W), .PTR_W(PTR_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .idx_load(idx_load), .lane_in(lane_in), .auto_inc(auto_inc),
    .word_in(word_in), .byte_in(byte_in), .ptr_load(ptr_load),
    .res_valid(res_valid), .result(result), .lane_idx(lane_idx),
    .dst_ptr(dst_ptr), .src_ptr(src_ptr)
);

// File: tb/byte_lane_unit_test.sv
module byte_lane_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic        op_kind = 1'b0;
    logic        idx_load = 1'b0;
    logic [1:0]  lane_in = '0;
    logic        auto_inc = 1'b0;
    logic [31:0] word_in = '0;
    logic [7:0]  byte_in = '0;
    logic        ptr_load = 1'b0;
    logic [8:0]  dst_ptr_in = '0;
    logic [8:0]  src_ptr_in = '0;
    logic        res_valid;
    logic [31:0] result;
    logic [1:0]  lane_idx;
    logic [8:0]  dst_ptr;
    logic [8:0]  src_ptr;

    always #10 clk = ~clk;

    byte_lane_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .idx_load(idx_load), .lane_in(lane_in), .auto_inc(auto_inc),
        .word_in(word_in), .byte_in(byte_in), .ptr_load(ptr_load),
        .dst_ptr_in(dst_ptr_in), .src_ptr_in(src_ptr_in),
        .res_valid(res_valid), .result(result), .lane_idx(lane_idx),
        .dst_ptr(dst_ptr), .src_ptr(src_ptr)
    );

    typedef struct {
        logic [31:0] res;
        logic [1:0]  idx;
        logic [8:0]  dst;
        logic [8:0]  src;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_run = 0;
    int          n_fail = 0;
    logic [1:0]  m_idx = '0;
    logic [8:0]  m_dst = '0;
    logic [8:0]  m_src = '0;
    logic [31:0] m_last = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one operation, expectation pushed to the scoreboard
    task automatic do_op(input logic kind, input logic ld, input logic [1:0] ln,
                         input logic ai, input logic [31:0] w, input logic [7:0] b,
                         input logic pl, input logic [8:0] pd, input logic [8:0] ps,
                         input string tag);
        exp_t e;
        logic [1:0] used;
        @(negedge clk);
        op_valid = 1'b1; op_kind = kind; idx_load = ld; lane_in = ln;
        auto_inc = ai; word_in = w; byte_in = b;
        ptr_load = pl; dst_ptr_in = pd; src_ptr_in = ps;
        used = ld ? ln : m_idx;
        if (!kind) e.res = (w & ~(32'hFF << (8*used))) | ({24'h0, b} << (8*used));
        else       e.res = (w >> (8*used)) & 32'hFF;
        if (ai) begin
            if (used == 2'd3) begin
                if (!kind) m_dst = m_dst + 9'd1;
                else       m_src = m_src + 9'd1;
            end
            m_idx = used + 2'd1;
        end else begin
            m_idx = used;
        end
        if (pl) begin m_dst = pd; m_src = ps; end
        m_last = e.res;
        e.idx = m_idx; e.dst = m_dst; e.src = m_src; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0; ptr_load = 1'b0;
        end
    endtask

    // monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb.size() == 0) begin
                check("R4 unexpected res_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " result"}, result, e.res);
                check({e.tag, " lane_idx"}, {30'd0, lane_idx}, {30'd0, e.idx});
                check({e.tag, " dst_ptr"}, {23'd0, dst_ptr}, {23'd0, e.dst});
                check({e.tag, " src_ptr"}, {23'd0, src_ptr}, {23'd0, e.src});
            end
        end
    end

    bit done = 0;
    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 res_valid", {31'd0, res_valid}, 32'd0);
        check("R11 result", result, 32'd0);
        check("R11 lane_idx", {30'd0, lane_idx}, 32'd0);
        check("R11 dst_ptr", {23'd0, dst_ptr}, 32'd0);
        check("R11 src_ptr", {23'd0, src_ptr}, 32'd0);

        // R1 R2: insert each lane explicitly, distinct bytes
        for (int k = 0; k < 4; k++)
            do_op(1'b0, 1'b1, 2'(k), 1'b0, 32'h4433_2211, 8'hA0 + 8'(k), 1'b0, '0, '0, "R2 insert lane");
        // R1 R3: extract each lane explicitly
        for (int k = 0; k < 4; k++)
            do_op(1'b1, 1'b1, 2'(k), 1'b0, 32'hD4C3_B2A1, 8'h00, 1'b0, '0, '0, "R3 extract lane");
        do_op(1'b1, 1'b1, 2'd2, 1'b0, 32'hFFFF_FFFF, 8'h00, 1'b0, '0, '0, "R3 zero-extend");
        idle(1);
        // R4: idle cycles, result held, no valid
        idle(2);
        check("R4 idle res_valid", {31'd0, res_valid}, 32'd0);
        check("R4 idle hold", result, m_last);

        // R5 R7: held index used with auto off, state holds
        do_op(1'b1, 1'b0, 2'd0, 1'b0, 32'h8877_6655, 8'h00, 1'b0, '0, '0, "R5 R7 held index");
        do_op(1'b0, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 8'h5A, 1'b0, '0, '0, "R7 no advance");

        // R6 R8: insert stream of 8 from lane 0, crossing wrap twice
        do_op(1'b0, 1'b1, 2'd0, 1'b1, 32'h1234_5678, 8'h01, 1'b0, '0, '0, "R6 insert stream");
        for (int k = 1; k < 8; k++)
            do_op(1'b0, 1'b0, 2'd0, 1'b1, 32'h1234_5678, 8'(k+1), 1'b0, '0, '0, "R8 insert stream");
        // R6 R9: extract stream of 8 with held index
        for (int k = 0; k < 8; k++)
            do_op(1'b1, 1'b0, 2'd0, 1'b1, 32'hCAFE_BABE, 8'h00, 1'b0, '0, '0, "R9 extract stream");
        idle(2);

        // R10: pointer load alone, checked at the ports
        @(negedge clk);
        ptr_load = 1'b1; dst_ptr_in = 9'h1FF; src_ptr_in = 9'h1FE;
        m_dst = 9'h1FF; m_src = 9'h1FE;
        @(negedge clk);
        ptr_load = 1'b0;
        check("R10 dst load", {23'd0, dst_ptr}, 32'h1FF);
        check("R10 src load", {23'd0, src_ptr}, 32'h1FE);
        // R8: modulo wrap of dst at maximum
        do_op(1'b0, 1'b1, 2'd3, 1'b1, 32'h0, 8'h77, 1'b0, '0, '0, "R8 dst modulo");
        // R9: src advance across its maximum
        do_op(1'b1, 1'b1, 2'd3, 1'b1, 32'hAB00_0000, 8'h00, 1'b0, '0, '0, "R9 src advance");
        do_op(1'b1, 1'b1, 2'd3, 1'b1, 32'hCD00_0000, 8'h00, 1'b0, '0, '0, "R9 src modulo");
        // R10: load collides with a wrap, load wins
        do_op(1'b0, 1'b1, 2'd3, 1'b1, 32'h0, 8'h11, 1'b1, 9'd40, 9'd50, "R10 load priority");
        idle(2);

        // R11: reset mid-stream
        do_op(1'b0, 1'b1, 2'd1, 1'b1, 32'h0, 8'h22, 1'b0, '0, '0, "R6 pre-reset");
        idle(2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_idx = '0; m_dst = '0; m_src = '0;
        check("R11 mid lane_idx", {30'd0, lane_idx}, 32'd0);
        check("R11 mid dst_ptr", {23'd0, dst_ptr}, 32'd0);
        check("R11 mid result", result, 32'd0);
        check("R11 mid res_valid", {31'd0, res_valid}, 32'd0);

        idle(2);
        check("R4 scoreboard drained", sb.size(), 32'd0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule